// File: doc/BRIEF.md
# Charge Pump Fast-Acquire Current Selector

This block chooses the charge-pump current multiple for the next phase-detector pulse of a PLL, based on how long the previous pulse lasted. It runs on one fast synchronous clock. It receives a sampled phase-detector pulse, a single-cycle reference tick, a divisor, a nominal current code and a fast-acquire enable. While a pulse is high, the block counts the reference ticks. An inner counter wraps every divisor ticks, and an outer counter counts the wraps. One wrap is one interval T.

When the pulse falls, the block turns the number of whole intervals into a current multiple. It raises that multiple to the nominal setting if the nominal setting is larger, and to a floor of two when fast acquire is on. The result is held until the next pulse ends, and a one-cycle strobe marks each new result. With fast acquire off, the output follows the nominal code.

The controller has three states. ST_IDLE waits for a pulse. ST_MEASURE counts ticks while the pulse is high. ST_REPORT lasts one cycle after the fall and raises the strobe. The transitions are:

- start: ST_IDLE or ST_REPORT to ST_MEASURE, when the pulse is sampled high. This clears the counters and captures the divisor.
- fall: ST_MEASURE to ST_REPORT, when the pulse is sampled low. This latches the result.
- rest: ST_REPORT to ST_IDLE, when no new pulse is present.

Top module: `cp_fastacq_ctrl`

## Requirements
- R1: A divisor value D gives an interval T of D reference ticks. A divisor of 0 is treated as 1.
- R2: With fast acquire on and nominal code 0, a pulse that contained n reference ticks gives mult_code = floor(n/T). mult_code is the multiple minus one.
- R3: The measured code saturates at 7, which is a multiple of 8, however long the pulse is.
- R4: With fast acquire on, the latched code is the larger of the measured code and nom_code.
- R5: With fast acquire on and nom_code 0, the latched code is never below 1, which is a multiple of 2.
- R6: With fast acquire off, mult_code equals nom_code at all times.
- R7: The pulse is sampled on a rising clock edge. In the cycle after the first sample of pulse low, mult_valid is 1 for exactly one cycle and mult_code shows the new result. The result then holds until the next report.
- R8: A change of the divisor while a pulse is high has no effect on that pulse. The divisor is captured when the pulse starts.
- R9: After reset, mult_valid is 0 and mult_code equals nom_code until the first report.
- R10: Reference ticks while the pulse is low are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast synchronous clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_pulse | input | 1 | Sampled phase-detector pulse |
| ref_tick | input | 1 | Single-cycle reference tick |
| div_val | input | 14 | Interval divisor, in reference ticks |
| nom_code | input | 3 | Nominal current code (multiple minus one) |
| fa_en | input | 1 | Fast-acquire enable |
| mult_code | output | 3 | Selected current multiple minus one |
| mult_valid | output | 1 | One-cycle strobe for a new result |

## Verification
On every cycle, the assertions check the following:

- the inner counter stays below the captured divisor;
- the captured divisor does not move during a pulse;
- the step count stays at its ceiling once it gets there;
- the strobe never lasts two cycles;
- a reported code never falls below the floor or the nominal code.

Only the bench scenarios can show the exact arithmetic. They sweep divisors, tick counts, tick spacings and nominal codes, and check the code against floor(n/T). The scenarios also cover ticks between pulses, a divisor changed in mid-pulse, and the reset value.

// File: rtl/cpfa_pkg.sv
package cpfa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_REPORT  = 2'd2
    } cpfa_state_e;
endpackage

// File: rtl/cpfa_width_counter.sv
module cpfa_width_counter #(
    parameter int DIV_W  = 14,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cnt,
    input  logic [DIV_W-1:0]  div_in,
    output logic [CODE_W-1:0] steps
);
    localparam logic [CODE_W-1:0] STEP_MAX = {CODE_W{1'b1}};

    logic [DIV_W-1:0]  inner_q, div_q;
    logic [CODE_W-1:0] outer_q;
    logic [DIV_W-1:0]  inner_base, lim;
    logic [CODE_W-1:0] outer_base;

    // A zero divisor acts as one (R1); the divisor is captured only at the start of a pulse (R8)
    always_comb begin
        inner_base = clr ? '0 : inner_q;
        outer_base = clr ? '0 : outer_q;
        if (clr) lim = (div_in == '0) ? DIV_W'(1) : div_in;
        else     lim = div_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inner_q <= '0;
            outer_q <= '0;
            div_q   <= DIV_W'(1);
        end else begin
            if (clr) div_q <= lim;
            if (cnt) begin
                if (inner_base == lim - DIV_W'(1)) begin
                    inner_q <= '0;
                    outer_q <= (outer_base == STEP_MAX) ? STEP_MAX : outer_base + CODE_W'(1);
                end else begin
                    inner_q <= inner_base + DIV_W'(1);
                    outer_q <= outer_base;
                end
            end else begin
                inner_q <= inner_base;
                outer_q <= outer_base;
            end
        end
    end

    assign steps = outer_q;

    a_r1_inner_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        inner_q < div_q);
    a_r8_div_held: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $stable(div_q));
    a_r3_steps_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (outer_q == STEP_MAX && !clr) |=> outer_q == STEP_MAX);
endmodule

// File: rtl/cpfa_mult_select.sv
module cpfa_mult_select #(
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] steps,
    input  logic [CODE_W-1:0] nom,
    input  logic              fa_en,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] bigger;

    always_comb begin
        bigger = (steps > nom) ? steps : nom;
        if (!fa_en)              code = nom;
        else if (bigger == '0)   code = CODE_W'(1);   // floor of two times minimum (R5)
        else                     code = bigger;       // R4
    end
endmodule

// File: rtl/cp_fastacq_ctrl.sv
module cp_fastacq_ctrl #(
    parameter int DIV_W  = 14,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_pulse,
    input  logic              ref_tick,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [CODE_W-1:0] nom_code,
    input  logic              fa_en,
    output logic [CODE_W-1:0] mult_code,
    output logic              mult_valid
);
    import cpfa_pkg::*;

    cpfa_state_e state_q, state_d;
    logic [CODE_W-1:0] steps, sel_code, held_q;
    logic have_q;
    logic start, fall, cnt;

    assign start = (state_q != ST_MEASURE) && pd_pulse;
    assign fall  = (state_q == ST_MEASURE) && !pd_pulse;
    assign cnt   = pd_pulse && ref_tick;           // R10: only ticks inside the pulse

    cpfa_width_counter #(.DIV_W(DIV_W), .CODE_W(CODE_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(start), .cnt(cnt),
        .div_in(div_val), .steps(steps)
    );

    cpfa_mult_select #(.CODE_W(CODE_W)) sel_i (
        .steps(steps), .nom(nom_code), .fa_en(fa_en), .code(sel_code)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (pd_pulse)  state_d = ST_MEASURE;
            ST_MEASURE: if (!pd_pulse) state_d = ST_REPORT;
            ST_REPORT:  state_d = pd_pulse ? ST_MEASURE : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            have_q <= 1'b0;
        end else if (fall) begin
            held_q <= sel_code;
            have_q <= 1'b1;
        end
    end

    always_comb begin
        mult_valid = (state_q == ST_REPORT);
        mult_code  = (fa_en && have_q) ? held_q : nom_code;
    end

    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        mult_valid |=> !mult_valid);
    a_r7_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && !pd_pulse) |=> mult_valid);
    a_r5_floor_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_valid && fa_en && $past(fa_en)) |-> mult_code != '0);
    a_r4_not_below_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_valid && fa_en && $past(fa_en) && $stable(nom_code)) |-> mult_code >= nom_code);
endmodule

// File: tb/cp_fastacq_ctrl_tb_top.sv
module cp_fastacq_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_pulse = 1'b0, ref_tick = 1'b0, fa_en = 1'b0;
    logic [13:0] div_val = '0;
    logic [2:0]  nom_code = '0;
    logic [2:0]  mult_code;
    logic        mult_valid;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    cp_fastacq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pd_pulse(pd_pulse), .ref_tick(ref_tick),
        .div_val(div_val), .nom_code(nom_code), .fa_en(fa_en),
        .mult_code(mult_code), .mult_valid(mult_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_code(int n, int d, int nom, bit fa);
        int t, s;
        if (!fa) return nom;
        t = (d == 0) ? 1 : d;
        s = n / t;
        if (s > 7) s = 7;
        if (nom > s) s = nom;
        if (s < 1) s = 1;
        return s;
    endfunction

    // pulse carrying n ticks, one tick every sp cycles; gap cycles carry stray ticks
    task automatic run_pulse(int n, int sp, int new_div, int chg_at, string req, int exp);
        int len;
        len = (n == 0) ? 1 : n * sp;
        for (int i = 0; i < len; i++) begin
            pd_pulse = 1'b1;
            ref_tick = (i % sp == 0) && (n > 0);
            if (i == chg_at) div_val = 14'(new_div);
            @(posedge clk); @(negedge clk);
        end
        pd_pulse = 1'b0;
        ref_tick = 1'b1;                       // R10 stray tick while low
        @(posedge clk); @(negedge clk);
        chk({req, " R7 strobe"}, mult_valid, 1);
        chk(req, mult_code, exp);
        @(posedge clk); @(negedge clk);
        chk("R7 strobe drop", mult_valid, 0);
        chk("R7 hold", mult_code, exp);
        ref_tick = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int divs[5] = '{0, 1, 2, 3, 5};
        int noms[3] = '{0, 2, 5};
        nom_code = 3'd3;
        fa_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset valid", mult_valid, 0);
        chk("R9 reset code", mult_code, 3);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R9 code before report", mult_code, 3);

        foreach (divs[di]) begin
            foreach (noms[ni]) begin
                for (int fa = 0; fa < 2; fa++) begin
                    for (int sp = 1; sp <= 2; sp++) begin
                        int dmax;
                        dmax = (divs[di] == 0) ? 1 : divs[di];
                        for (int n = 0; n <= 8 * dmax + 2; n++) begin
                            int ex;
                            div_val = 14'(divs[di]);
                            nom_code = 3'(noms[ni]);
                            fa_en = fa[0];
                            ex = expect_code(n, divs[di], noms[ni], fa[0]);
                            if (!fa[0])                 run_pulse(n, sp, divs[di], -1, "R6 nominal", ex);
                            else if (n >= 8 * dmax)     run_pulse(n, sp, divs[di], -1, "R3 cap", ex);
                            else if (noms[ni] != 0)     run_pulse(n, sp, divs[di], -1, "R4 nominal max", ex);
                            else if (n < dmax)          run_pulse(n, sp, divs[di], -1, "R5 floor", ex);
                            else                        run_pulse(n, sp, divs[di], -1, "R1 R2 width", ex);
                        end
                    end
                end
            end
        end

        // R8: divisor 2 at start, changed to 1 mid-pulse; 6 ticks -> 3
        fa_en = 1'b1; nom_code = 3'd0; div_val = 14'd2;
        run_pulse(6, 1, 1, 2, "R8 divisor held", 3);
        // next pulse picks up divisor 1: 6 ticks -> 6
        run_pulse(6, 1, 1, -1, "R8 new divisor applied", 6);
        // R6: disabling fast acquire reverts output at once
        fa_en = 1'b0; nom_code = 3'd4;
        @(posedge clk); @(negedge clk);
        chk("R6 disable immediate", mult_code, 4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule